// File: doc/BRIEF.md
# Bus-Master Channel Control Register Bank

This block is the I/O register bank of one disk-channel bus-master DMA engine. It has an eight-byte window: a command byte, a status byte and a 32-bit pointer to the descriptor table. Software may touch the window with byte, halfword or word accesses at any byte offset. Each access is split into byte lanes. A lane beyond the window, or one that maps to a reserved byte, is dropped.

The bank produces the control side of the descriptor walker, which sits outside this block. It drives a one-cycle pointer-load pulse together with the table base, a one-cycle kick when a transfer is already waiting, the active flag, the transfer direction, and a halting flag. Halting is high while a stop request waits for the transfer in flight to finish. The device interrupt passes straight through to the output. Each rising edge of that interrupt is latched into status.

Top module: `busmaster_ctl_regs`

## Requirements
- R1: A write to byte offset 0 keeps only bit 0 (start) and bit 3 (direction). A read of offset 0 returns the written value ANDed with 0x09, and `dir` follows bit 3.
- R2: A command write that leaves the start bit at its stored value produces no `ptr_load` or `kick` pulse and leaves `active` unchanged.
- R3: A command write that changes start from 0 to 1 does three things in the cycle after the write edge. It raises `ptr_load` for one cycle, with `ptr_value` equal to the base register. It sets `active`. It also raises `kick` for one cycle, but only if `active` was clear and `xfer_pending` was high at the write edge.
- R4: A command write that changes start from 1 to 0 clears `active` at that edge when `xfer_busy` is low. When `xfer_busy` is high, it raises `halting` and keeps `active` set until the first edge at which `xfer_busy` is sampled low. At that edge both `active` and `halting` clear.
- R5: A high `walk_end` at a clock edge clears `active` and `halting`, unless a start edge is written at the same edge.
- R6: The base register occupies offsets 4 to 7, least significant byte at offset 4. A write updates only the lanes it covers, and bits 1:0 always read zero.
- R7: A read returns the window shifted right by 8 times the offset and masked to the access width. The window is laid out as follows: byte 0 is command, byte 2 is status, bytes 4 to 7 are the base, and all other bytes read zero. The access size is coded 0 = byte, 1 = halfword, 2 or 3 = word.
- R8: `irq_out` equals `dev_irq` at all times. A rising `dev_irq` sets status bit 2 one edge later. A falling `dev_irq` leaves status unchanged.
- R9: Status bit 1 is set by `err_evt`. Status bits 1 and 2 clear when a 1 is written to them. A set and a clear at the same edge leave the bit set.
- R10: Status bits 5 and 6 are plain read/write. Bit 0 reads the active flag and ignores writes. Bits 3, 4 and 7 read zero.
- R11: While `rst_n` is low, every register and output pulse is zero. Its release takes effect through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 3 | Byte offset in the window |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_wdata | input | 32 | Write data, lane 0 at the offset |
| acc_rdata | output | 32 | Read data (combinational) |
| xfer_pending | input | 1 | Walker has a transfer waiting to start |
| xfer_busy | input | 1 | Walker has a transfer in flight |
| walk_end | input | 1 | Walker reached the end of its table |
| err_evt | input | 1 | Error event, sets status bit 1 |
| dev_irq | input | 1 | Device interrupt level |
| irq_out | output | 1 | Interrupt passed through |
| ptr_load | output | 1 | Walker pointer reload pulse |
| ptr_value | output | 32 | Base address for the walker |
| kick | output | 1 | Start-pending-transfer pulse |
| active | output | 1 | Channel active flag |
| dir | output | 1 | Transfer direction bit |
| halting | output | 1 | Stop requested, waiting on drain |

## Verification
Faults in the stored start bit show up in the next cycle. A start bit that stays stuck, or one that captures the wrong lane, produces a missing or spurious `ptr_load`, and `active` flips at the wrong edge. A halting flag that was never set, or never cleared, is visible within one edge of `xfer_busy` falling, because `active` clears early or not at all. A lost interrupt edge or a wrong clear mask is visible on the next status read. Comparing every output against a behavioural model after every edge catches each of these within one cycle.

// File: rtl/busmaster_ctl_pkg.sv
package busmaster_ctl_pkg;
  // Byte positions of the registers inside the access window
  localparam int unsigned LANE_CMD  = 0;
  localparam int unsigned LANE_STAT = 2;
  localparam int unsigned LANE_BASE = 4;

  // Command bits
  localparam int unsigned CMD_START = 0;
  localparam int unsigned CMD_DIR   = 3;

  // Status bits
  localparam int unsigned ST_ACT  = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_INT  = 2;
  localparam int unsigned ST_CAPA = 5;
  localparam int unsigned ST_CAPB = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/busmaster_ctl_lanes.sv
module busmaster_ctl_lanes
  import busmaster_ctl_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 8,
  parameter int unsigned BUS_BYTES = 4,
  localparam int unsigned OFF_W    = $clog2(WIN_BYTES),
  localparam int unsigned CNT_W    = OFF_W + 2
) (
  input  logic                     acc_en,
  input  logic                     acc_wr,
  input  logic [OFF_W-1:0]         acc_off,
  input  logic [1:0]               acc_size,
  input  logic [8*BUS_BYTES-1:0]   acc_wdata,
  output logic [WIN_BYTES-1:0]     lane_we,
  output logic [WIN_BYTES-1:0][7:0] lane_wdata,
  output logic [CNT_W-1:0]         nbytes
);
  logic [CNT_W-1:0] off_ext;
  logic [CNT_W-1:0] raw_n;

  assign off_ext = CNT_W'(acc_off);

  always_comb begin
    unique case (acc_size_e'(acc_size))
      SZ_BYTE: raw_n = CNT_W'(1);
      SZ_HALF: raw_n = CNT_W'(2);
      default: raw_n = CNT_W'(4);
    endcase
    nbytes = (raw_n > CNT_W'(BUS_BYTES)) ? CNT_W'(BUS_BYTES) : raw_n;
  end

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_lane
    localparam logic [CNT_W-1:0] KL = CNT_W'(k);
    logic [CNT_W-1:0]       idx;
    logic [8*BUS_BYTES-1:0] shifted;
    assign idx        = KL - off_ext;
    assign shifted    = acc_wdata >> {idx, 3'b000};
    assign lane_wdata[k] = shifted[7:0];
    assign lane_we[k] = acc_en && acc_wr && (KL >= off_ext) && (KL < off_ext + nbytes);
  end
endmodule

// File: rtl/busmaster_ctl_cmd.sv
module busmaster_ctl_cmd (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_we,
  input  logic wr_start,
  input  logic wr_dir,
  input  logic xfer_pending,
  input  logic xfer_busy,
  input  logic walk_end,
  output logic start_o,
  output logic dir_o,
  output logic active_o,
  output logic halting_o,
  output logic load_o,
  output logic kick_o
);
  logic start_q, dir_q, act_q, halt_q, load_q, kick_q;
  logic start_d, dir_d, act_d, halt_d, load_d, kick_d;
  logic rise, fall;

  assign rise = cmd_we &&  wr_start && !start_q;
  assign fall = cmd_we && !wr_start &&  start_q;

  always_comb begin
    start_d = start_q;
    dir_d   = dir_q;
    act_d   = act_q;
    halt_d  = halt_q;
    load_d  = 1'b0;
    kick_d  = 1'b0;
    if (walk_end) begin
      act_d  = 1'b0;
      halt_d = 1'b0;
    end
    if (halt_q && !xfer_busy) begin
      act_d  = 1'b0;
      halt_d = 1'b0;
    end
    if (cmd_we) begin
      start_d = wr_start;
      dir_d   = wr_dir;
    end
    if (rise) begin
      load_d = 1'b1;
      halt_d = 1'b0;
      act_d  = 1'b1;
      kick_d = !act_q && xfer_pending;
    end else if (fall) begin
      if (xfer_busy) begin
        halt_d = 1'b1;
      end else begin
        act_d  = 1'b0;
        halt_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      act_q   <= 1'b0;
      halt_q  <= 1'b0;
      load_q  <= 1'b0;
      kick_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      dir_q   <= dir_d;
      act_q   <= act_d;
      halt_q  <= halt_d;
      load_q  <= load_d;
      kick_q  <= kick_d;
    end
  end

  assign start_o   = start_q;
  assign dir_o     = dir_q;
  assign active_o  = act_q;
  assign halting_o = halt_q;
  assign load_o    = load_q;
  assign kick_o    = kick_q;

  // R3: a reload pulse only follows a 0-to-1 change of the stored start bit
  p_load_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> (start_q && !$past(start_q)));
  // R3: a kick always comes together with a reload and an active channel
  p_kick_with_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |-> (load_q && act_q));
  // R4: once the drain is seen, the channel goes inactive
  p_stop_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !xfer_busy && !cmd_we) |=> !act_q);
  // R2: rewriting the same start value does nothing
  p_same_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && (wr_start == start_q) && !walk_end && !halt_q) |=> ($stable(act_q) && !load_q));
endmodule

// File: rtl/busmaster_ctl_stat.sv
module busmaster_ctl_stat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_we,
  input  logic       clr_err,
  input  logic       clr_int,
  input  logic [1:0] cap_wr,
  input  logic       err_evt,
  input  logic       dev_irq,
  output logic       err_o,
  output logic       int_o,
  output logic [1:0] cap_o
);
  logic       irq_q, err_q, int_q;
  logic [1:0] cap_q;
  logic       irq_d, err_d, int_d;
  logic [1:0] cap_d;
  logic       irq_rise;

  assign irq_rise = dev_irq && !irq_q;

  always_comb begin
    irq_d = dev_irq;
    err_d = (err_q && !(stat_we && clr_err)) || err_evt;
    int_d = (int_q && !(stat_we && clr_int)) || irq_rise;
    cap_d = stat_we ? cap_wr : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
      int_q <= 1'b0;
      cap_q <= 2'b00;
    end else begin
      irq_q <= irq_d;
      err_q <= err_d;
      int_q <= int_d;
      cap_q <= cap_d;
    end
  end

  assign err_o = err_q;
  assign int_o = int_q;
  assign cap_o = cap_q;

  // R8: a rising device interrupt is always latched
  p_irq_rise_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq && !irq_q) |=> int_q);
  // R8: a falling device interrupt does not disturb the latched flag
  p_irq_fall_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_irq && irq_q && !(stat_we && clr_int)) |=> (int_q == $past(int_q)));
  // R9: an error event wins over a simultaneous clear
  p_err_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err_q);
endmodule

// File: rtl/busmaster_ctl_regs.sv
module busmaster_ctl_regs
  import busmaster_ctl_pkg::*;
#(
  parameter int unsigned BUS_BYTES  = 4,
  parameter int unsigned BASE_BYTES = 4,
  localparam int unsigned WIN_BYTES = LANE_BASE + BASE_BYTES,
  localparam int unsigned OFF_W     = $clog2(WIN_BYTES),
  localparam int unsigned CNT_W     = OFF_W + 2,
  localparam int unsigned BUS_W     = 8 * BUS_BYTES,
  localparam int unsigned BASE_W    = 8 * BASE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [1:0]        acc_size,
  input  logic [BUS_W-1:0]  acc_wdata,
  output logic [BUS_W-1:0]  acc_rdata,
  input  logic              xfer_pending,
  input  logic              xfer_busy,
  input  logic              walk_end,
  input  logic              err_evt,
  input  logic              dev_irq,
  output logic              irq_out,
  output logic              ptr_load,
  output logic [BASE_W-1:0] ptr_value,
  output logic              kick,
  output logic              active,
  output logic              dir,
  output logic              halting
);
  // Reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [WIN_BYTES-1:0]      lane_we;
  logic [WIN_BYTES-1:0][7:0] lane_wdata;
  logic [CNT_W-1:0]          nbytes;

  busmaster_ctl_lanes #(.WIN_BYTES(WIN_BYTES), .BUS_BYTES(BUS_BYTES)) u_lanes (
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_off   (acc_off),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .lane_we   (lane_we),
    .lane_wdata(lane_wdata),
    .nbytes    (nbytes)
  );

  logic start_q;
  busmaster_ctl_cmd u_cmd (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .cmd_we      (lane_we[LANE_CMD]),
    .wr_start    (lane_wdata[LANE_CMD][CMD_START]),
    .wr_dir      (lane_wdata[LANE_CMD][CMD_DIR]),
    .xfer_pending(xfer_pending),
    .xfer_busy   (xfer_busy),
    .walk_end    (walk_end),
    .start_o     (start_q),
    .dir_o       (dir),
    .active_o    (active),
    .halting_o   (halting),
    .load_o      (ptr_load),
    .kick_o      (kick)
  );

  logic       st_err, st_int;
  logic [1:0] st_cap;
  busmaster_ctl_stat u_stat (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .stat_we (lane_we[LANE_STAT]),
    .clr_err (lane_wdata[LANE_STAT][ST_ERR]),
    .clr_int (lane_wdata[LANE_STAT][ST_INT]),
    .cap_wr  ({lane_wdata[LANE_STAT][ST_CAPB], lane_wdata[LANE_STAT][ST_CAPA]}),
    .err_evt (err_evt),
    .dev_irq (dev_irq),
    .err_o   (st_err),
    .int_o   (st_int),
    .cap_o   (st_cap)
  );

  assign irq_out = dev_irq;

  // Descriptor table base, one register per byte lane
  logic [BASE_W-1:0] base_q;
  for (genvar j = 0; j < BASE_BYTES; j++) begin : g_base
    logic [7:0] byte_d;
    always_comb begin
      byte_d = lane_wdata[LANE_BASE + j];
      if (j == 0) byte_d[1:0] = 2'b00;
    end
    always_ff @(posedge clk or negedge rst_sync_q) begin
      if (!rst_sync_q)               base_q[8*j +: 8] <= 8'h00;
      else if (lane_we[LANE_BASE + j]) base_q[8*j +: 8] <= byte_d;
    end
  end
  assign ptr_value = base_q;

  // Read path
  logic [7:0]             cmd_byte, stat_byte;
  logic [8*WIN_BYTES-1:0] window, shifted;
  logic [BUS_W-1:0]       rmask;

  always_comb begin
    cmd_byte            = 8'h00;
    cmd_byte[CMD_START] = start_q;
    cmd_byte[CMD_DIR]   = dir;
    stat_byte           = 8'h00;
    stat_byte[ST_ACT]   = active;
    stat_byte[ST_ERR]   = st_err;
    stat_byte[ST_INT]   = st_int;
    stat_byte[ST_CAPA]  = st_cap[0];
    stat_byte[ST_CAPB]  = st_cap[1];
    window                          = '0;
    window[8*LANE_CMD  +: 8]        = cmd_byte;
    window[8*LANE_STAT +: 8]        = stat_byte;
    window[8*LANE_BASE +: BASE_W]   = base_q;
    shifted = window >> {acc_off, 3'b000};
  end

  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_rmask
    assign rmask[8*b +: 8] = (CNT_W'(b) < nbytes) ? 8'hFF : 8'h00;
  end

  assign acc_rdata = shifted[BUS_W-1:0] & rmask;

  // R6: the walker never sees an unaligned table pointer after a load
  p_load_aligned_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ptr_load |-> (ptr_value[1:0] == 2'b00 && active));
  // R8: interrupt output tracks the device
  p_irq_pass_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(dev_irq) |-> irq_out);
endmodule

// File: tb/test_busmaster_ctl_regs.sv
module test_busmaster_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en, acc_wr;
  logic [2:0]  acc_off;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata, acc_rdata;
  logic        xfer_pending, xfer_busy, walk_end, err_evt, dev_irq;
  logic        irq_out, ptr_load, kick, active, dir, halting;
  logic [31:0] ptr_value;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  busmaster_ctl_regs i_busmaster_ctl_regs (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_off(acc_off), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .xfer_pending(xfer_pending), .xfer_busy(xfer_busy),
    .walk_end(walk_end), .err_evt(err_evt), .dev_irq(dev_irq),
    .irq_out(irq_out), .ptr_load(ptr_load), .ptr_value(ptr_value),
    .kick(kick), .active(active), .dir(dir), .halting(halting)
  );

  // Behavioural model state
  bit [7:0]  m_cmd;
  bit        m_act, m_halt, m_load, m_kick, m_err, m_int, m_irqp;
  bit [1:0]  m_cap;
  bit [31:0] m_base;

  function automatic int size_bytes(input bit [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic bit [63:0] model_window();
    bit [7:0] st;
    st = {1'b0, m_cap[1], m_cap[0], 2'b00, m_int, m_err, m_act};
    return {m_base, 8'h00, st, 8'h00, m_cmd};
  endfunction

  task automatic model_reset();
    m_cmd = 0; m_act = 0; m_halt = 0; m_load = 0; m_kick = 0;
    m_err = 0; m_int = 0; m_irqp = 0; m_cap = 0; m_base = 0;
  endtask

  task automatic model_edge();
    int n;
    bit [7:0] b;
    bit na, nh, nl, nk, old_start;
    bit [7:0] ncmd;
    bit [1:0] ncap;
    bit [31:0] nbase;
    bit clr_e, clr_i;
    if (!rst_n) begin model_reset(); return; end
    n = size_bytes(acc_size);
    na = m_act; nh = m_halt; nl = 0; nk = 0;
    ncmd = m_cmd; ncap = m_cap; nbase = m_base; clr_e = 0; clr_i = 0;
    old_start = m_cmd[0];
    if (walk_end) begin na = 0; nh = 0; end
    if (m_halt && !xfer_busy) begin na = 0; nh = 0; end
    for (int k = 0; k < 8; k++) begin
      if (acc_en && acc_wr && k >= acc_off && k < acc_off + n) begin
        b = 8'((acc_wdata >> (8 * (k - acc_off))) & 32'hFF);
        if (k == 0) begin
          ncmd = b & 8'h09;
          if (b[0] && !old_start) begin
            nl = 1; nh = 0; na = 1; nk = !m_act && xfer_pending;
          end else if (!b[0] && old_start) begin
            if (xfer_busy) nh = 1; else begin na = 0; nh = 0; end
          end
        end else if (k == 2) begin
          clr_e = b[1]; clr_i = b[2]; ncap = {b[6], b[5]};
        end else if (k >= 4) begin
          nbase[8*(k-4) +: 8] = b;
        end
      end
    end
    nbase[1:0] = 2'b00;
    m_err  = (m_err && !clr_e) || err_evt;
    m_int  = (m_int && !clr_i) || (dev_irq && !m_irqp);
    m_irqp = dev_irq;
    m_cmd = ncmd; m_cap = ncap; m_base = nbase;
    m_act = na; m_halt = nh; m_load = nl; m_kick = nk;
  endtask

  task automatic chk(input string req, input string what, input bit [31:0] act, input bit [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    bit [63:0] w;
    bit [31:0] mask;
    chk(req, "active",    32'(active),   32'(m_act));
    chk(req, "halting",   32'(halting),  32'(m_halt));
    chk(req, "ptr_load",  32'(ptr_load), 32'(m_load));
    chk(req, "kick",      32'(kick),     32'(m_kick));
    chk(req, "dir",       32'(dir),      32'(m_cmd[3]));
    chk(req, "ptr_value", ptr_value,     m_base);
    chk(req, "irq_out",   32'(irq_out),  32'(dev_irq));
    if (acc_en && !acc_wr) begin
      w = model_window() >> (8 * acc_off);
      mask = (size_bytes(acc_size) == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * size_bytes(acc_size))) - 1);
      chk(req, "rdata", acc_rdata, w[31:0] & mask);
    end
  endtask

  // Inputs are set after a falling edge; compare, then advance one edge
  task automatic tick(input string req);
    #1 compare(req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    acc_en = 0; acc_wr = 0; acc_off = 0; acc_size = 0; acc_wdata = 0;
    walk_end = 0; err_evt = 0;
  endtask

  task automatic wr(input bit [2:0] off, input bit [1:0] sz, input bit [31:0] d, input string req);
    acc_en = 1; acc_wr = 1; acc_off = off; acc_size = sz; acc_wdata = d;
    tick(req);
    idle();
  endtask

  task automatic rd(input bit [2:0] off, input bit [1:0] sz, input string req);
    acc_en = 1; acc_wr = 0; acc_off = off; acc_size = sz; acc_wdata = 32'hDEAD_BEEF;
    tick(req);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    idle();
    xfer_pending = 0; xfer_busy = 0; dev_irq = 0;
    rst_n = 0;
    model_reset();
    @(negedge clk);
    tick("R11"); tick("R11");
    rst_n = 1;
    tick("R11"); tick("R11"); tick("R11");
    rd(0, 2, "R11"); rd(4, 2, "R11");

    // R1 / R3: start from idle, nothing pending
    wr(0, 0, 32'h0000_00FF, "R1");
    tick("R3");
    rd(0, 0, "R1");
    // R2: same start value rewritten, direction changes
    wr(0, 0, 32'h0000_0001, "R2");
    tick("R2");
    // R4: stop while busy
    xfer_busy = 1;
    wr(0, 0, 32'h0000_0000, "R4");
    tick("R4"); tick("R4");
    xfer_busy = 0;
    tick("R4"); tick("R4");

    // R6 / R7: base lanes and read shifting
    wr(4, 2, 32'h1234_5677, "R6");
    rd(4, 2, "R7"); rd(5, 0, "R7"); rd(6, 1, "R7"); rd(3, 2, "R7");
    wr(7, 0, 32'h0000_00AB, "R6");
    wr(4, 1, 32'h0000_FF03, "R6");
    rd(4, 3, "R6"); rd(1, 1, "R7"); rd(6, 2, "R7");
    wr(6, 2, 32'hCAFE_5A5A, "R6");
    rd(4, 2, "R6");

    // R3: start with transfer pending kicks the walker
    xfer_pending = 1;
    wr(0, 0, 32'h0000_0009, "R3");
    tick("R3");
    // R2: rewrite while active, pending
    wr(0, 0, 32'h0000_0001, "R2");
    // R4: stop with no transfer in flight
    xfer_pending = 0;
    wr(0, 0, 32'h0000_0008, "R4");
    tick("R4");
    // R5: walker reaches the end of its table
    wr(0, 0, 32'h0000_0001, "R3");
    walk_end = 1; tick("R5"); walk_end = 0;
    tick("R5");
    // R4: stop request cancelled by a new start
    xfer_busy = 1;
    wr(0, 0, 32'h0000_0000, "R4");
    xfer_pending = 1;
    wr(0, 0, 32'h0000_0001, "R3");
    xfer_busy = 0; xfer_pending = 0;
    tick("R4");

    // R8: interrupt rise, hold, fall
    dev_irq = 1; tick("R8"); tick("R8");
    rd(2, 0, "R8");
    dev_irq = 0; tick("R8");
    rd(2, 0, "R8");
    // R9: clears and error events
    wr(2, 0, 32'h0000_0004, "R9");
    rd(2, 0, "R9");
    err_evt = 1; tick("R9"); err_evt = 0;
    rd(2, 0, "R9");
    dev_irq = 1;
    acc_en = 1; acc_wr = 1; acc_off = 2; acc_size = 0; acc_wdata = 32'h06; err_evt = 1;
    tick("R9");
    idle();
    rd(2, 0, "R9");
    wr(2, 0, 32'h0000_0006, "R9");
    rd(2, 0, "R9");
    dev_irq = 0;
    // R10: plain bits, read-only active, reserved bits
    wr(2, 0, 32'h0000_00FF, "R10");
    rd(2, 0, "R10");
    wr(2, 0, 32'h0000_0020, "R10");
    rd(0, 2, "R10");
    // Word write spanning command and status lanes
    wr(0, 2, 32'h00FB_FF08, "R1");
    rd(0, 2, "R7");
    tick("R4");

    // R11: reset in the middle of activity
    wr(4, 2, 32'h8000_0010, "R6");
    wr(0, 0, 32'h0000_0009, "R3");
    dev_irq = 1; tick("R8");
    rst_n = 0; model_reset(); dev_irq = 0;
    tick("R11"); tick("R11");
    rst_n = 1;
    tick("R11"); tick("R11"); tick("R11");
    rd(0, 2, "R11"); rd(4, 2, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule